// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This block takes two single-precision IEEE-754 operands and performs an ordered scalar comparison between them. The outcome is one of four classes: greater, less, equal or unordered. It is stored in a registered condition-flag set made of zero, parity, carry, overflow, sign and auxiliary-carry bits. A mode input chooses how NaN operands are treated. In signalling mode any NaN raises the invalid exception. In quiet mode only a signalling NaN does.

Each exception has its own mask bit. A masked exception is recorded in a sticky status bit and the flags are written as usual. An unmasked exception is also recorded. In that case the flags keep their previous value and a single-cycle trap pulse is produced. All registered outputs change on the clock edge that samples the valid strobe.

Top module: `sfc_flag_unit`

## Requirements
- R1: After reset all six flags, both sticky exception bits and the trap output are 0.
- R2: An accepted compare writes {zf,pf,cf} as follows: 0,0,0 when operand A is greater than B; 0,0,1 when A is less than B; 1,0,0 when they are equal.
- R3: Every accepted compare that updates the flags writes overflow, sign and auxiliary-carry as 0.
- R4: When either operand is a NaN (exponent all ones and fraction nonzero), the result is unordered and {zf,pf,cf} is written as 1,1,1.
- R5: Negative zero and positive zero compare equal.
- R6: Finite values and infinities compare by sign and then magnitude. A positive value beats a negative one. Between two negative values the larger magnitude is the smaller value. Two infinities of the same sign compare equal.
- R7: In signalling mode (mode_sig_i=1) any NaN operand raises invalid. In quiet mode only a signalling NaN raises it, meaning a NaN whose fraction bit 22 is 0. The raised exception is seen in sticky_invalid_o.
- R8: An operand with exponent 0 and a nonzero fraction raises the denormal exception, which sets sticky_denormal_o. The value still compares by magnitude.
- R9: If an exception is raised and its mask bit is 0, the flags are not written. trap_o is 1 for exactly the one cycle after the compare.
- R10: If every raised exception is masked, the sticky bit is still set, the flags are written and trap_o stays 0.
- R11: With valid_i low the flags hold their value. Sticky bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Compare strobe; operands sampled on this edge |
| mode_sig_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| op_a_i | input | 32 | Operand A, single precision |
| op_b_i | input | 32 | Operand B, single precision |
| mask_invalid_i | input | 1 | 1 masks the invalid exception |
| mask_denormal_i | input | 1 | 1 masks the denormal exception |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| af_o | output | 1 | Auxiliary-carry flag |
| sticky_invalid_o | output | 1 | Sticky invalid exception status |
| sticky_denormal_o | output | 1 | Sticky denormal exception status |
| trap_o | output | 1 | One-cycle pulse for an unmasked exception |

## Verification
A wrong classification or magnitude decision shows up in {zf,pf,cf} one cycle after the strobe. The only exception is a compare whose flag write was suppressed, and there the error remains hidden until a later masked compare. A fault in the NaN-kind or subnormal detection shows up in the sticky bits in that same cycle, but only the first time after reset: once a sticky bit is set, it hides later errors. The tests therefore reset before each exception scenario. A broken suppression path appears as a flag change together with trap_o, and that is checked on the same sample.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    RES_GT = 2'd0,
    RES_LT = 2'd1,
    RES_EQ = 2'd2,
    RES_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
    logic ovf;
    logic sgn;
    logic aux;
  } flags_t;

  function automatic flags_t encode_flags(cmp_res_e res);
    flags_t f;
    f = '0;
    unique case (res)
      RES_GT: {f.zf, f.pf, f.cf} = 3'b000;
      RES_LT: {f.zf, f.pf, f.cf} = 3'b001;
      RES_EQ: {f.zf, f.pf, f.cf} = 3'b100;
      default: {f.zf, f.pf, f.cf} = 3'b111;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/sfc_classify.sv
module sfc_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op_i,
  output logic         sign_o,
  output logic [W-2:0] mag_o,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o,
  output logic         denorm_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_max, exp_min, frac_nz;

  assign sign_o  = op_i[W-1];
  assign mag_o   = op_i[W-2:0];
  assign exp_f   = op_i[W-2:FRAC_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign frac_nz = |frac_f;

  assign nan_o    = exp_max && frac_nz;
  // quiet bit is the fraction MSB
  assign snan_o   = nan_o && !frac_f[FRAC_W-1];
  assign zero_o   = exp_min && !frac_nz;
  assign denorm_o = exp_min && frac_nz;

  always_comb begin
    a_r7_snan_is_nan: assert (!snan_o || nan_o);
    a_r8_den_not_zero: assert (!(denorm_o && zero_o));
  end
endmodule

// File: rtl/sfc_order.sv
module sfc_order
  import sfc_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  input  logic             nan_a_i,
  input  logic             nan_b_i,
  input  logic             zero_a_i,
  input  logic             zero_b_i,
  output cmp_res_e         res_o
);
  logic a_gt_mag, mag_eq;

  assign a_gt_mag = mag_a_i > mag_b_i;
  assign mag_eq   = mag_a_i == mag_b_i;

  always_comb begin
    if (nan_a_i || nan_b_i)            res_o = RES_UN;
    else if (zero_a_i && zero_b_i)     res_o = RES_EQ;
    else if (sign_a_i != sign_b_i)     res_o = sign_a_i ? RES_LT : RES_GT;
    else if (mag_eq)                   res_o = RES_EQ;
    else if (a_gt_mag ^ sign_a_i)      res_o = RES_GT;
    else                               res_o = RES_LT;
  end

  always_comb begin
    a_r4_nan_unordered: assert (!(nan_a_i || nan_b_i) || res_o == RES_UN);
    a_r5_zero_equal: assert (!(zero_a_i && zero_b_i) || res_o == RES_EQ);
  end
endmodule

// File: rtl/sfc_flag_unit.sv
module sfc_flag_unit
  import sfc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W,
  localparam int N_OP  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         mode_sig_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         mask_invalid_i,
  input  logic         mask_denormal_i,
  output logic         zf_o,
  output logic         pf_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         sf_o,
  output logic         af_o,
  output logic         sticky_invalid_o,
  output logic         sticky_denormal_o,
  output logic         trap_o
);
  logic [N_OP-1:0][W-1:0] ops;
  logic [N_OP-1:0][W-2:0] mag;
  logic [N_OP-1:0] sgn, nan, snan, zro, den;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < N_OP; g++) begin : g_cls
    sfc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i    (ops[g]),
      .sign_o  (sgn[g]),
      .mag_o   (mag[g]),
      .nan_o   (nan[g]),
      .snan_o  (snan[g]),
      .zero_o  (zro[g]),
      .denorm_o(den[g])
    );
  end

  cmp_res_e res;
  sfc_order #(.MAG_W(W-1)) u_ord (
    .sign_a_i(sgn[0]), .sign_b_i(sgn[1]),
    .mag_a_i (mag[0]), .mag_b_i (mag[1]),
    .nan_a_i (nan[0]), .nan_b_i (nan[1]),
    .zero_a_i(zro[0]), .zero_b_i(zro[1]),
    .res_o   (res)
  );

  logic exc_inv, exc_den, unmasked;
  assign exc_inv  = mode_sig_i ? |nan : |snan;
  assign exc_den  = |den;
  assign unmasked = (exc_inv && !mask_invalid_i) || (exc_den && !mask_denormal_i);

  flags_t flags_q;
  logic   st_inv_q, st_den_q, trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      st_inv_q <= 1'b0;
      st_den_q <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      trap_q <= valid_i && unmasked;
      if (valid_i) begin
        st_inv_q <= st_inv_q | exc_inv;
        st_den_q <= st_den_q | exc_den;
        if (!unmasked) flags_q <= encode_flags(res);
      end
    end
  end

  assign zf_o              = flags_q.zf;
  assign pf_o              = flags_q.pf;
  assign cf_o              = flags_q.cf;
  assign of_o              = flags_q.ovf;
  assign sf_o              = flags_q.sgn;
  assign af_o              = flags_q.aux;
  assign sticky_invalid_o  = st_inv_q;
  assign sticky_denormal_o = st_den_q;
  assign trap_o            = trap_q;

  a_r9_hold_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unmasked) |=> $stable({zf_o, pf_o, cf_o}) && trap_o);
  a_r11_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({zf_o, pf_o, cf_o, of_o, sf_o, af_o}) && !trap_o);
  a_r11_sticky_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_invalid_o |=> sticky_invalid_o);
  a_r11_sticky_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_denormal_o |=> sticky_denormal_o);
  a_r2_parity_only_unordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_o |-> (zf_o && cf_o));
  a_r10_masked_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !unmasked && (exc_inv || exc_den)) |=> !trap_o);
endmodule

// File: tb/tb_sfc_flag_unit.sv
module tb_sfc_flag_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic valid, mode_sig, m_inv, m_den;
  logic [31:0] a, b;
  logic zf, pf, cf, ovf, sgn, aux, st_inv, st_den, trap;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] PMAX = 32'h7F7F_FFFF, QNAN = 32'h7FC0_0000;
  localparam logic [31:0] SNAN = 32'h7F80_0001, DEN = 32'h0000_0001;

  always #10 clk = ~clk;

  sfc_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .mode_sig_i(mode_sig),
    .op_a_i(a), .op_b_i(b), .mask_invalid_i(m_inv), .mask_denormal_i(m_den),
    .zf_o(zf), .pf_o(pf), .cf_o(cf), .of_o(ovf), .sf_o(sgn), .af_o(aux),
    .sticky_invalid_o(st_inv), .sticky_denormal_o(st_den), .trap_o(trap)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; valid = 1'b0; mode_sig = 1'b0; m_inv = 1'b1; m_den = 1'b1;
    a = '0; b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one compare; returns at the negedge after the capturing edge
  task automatic cmp(input logic [31:0] x, input logic [31:0] y, input logic sig,
                     input logic mi, input logic md);
    a = x; b = y; mode_sig = sig; m_inv = mi; m_den = md; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic ord(input string req, input logic [31:0] x, input logic [31:0] y,
                     input logic [2:0] exp);
    cmp(x, y, 1'b0, 1'b1, 1'b1);
    chk(req, {29'd0, zf, pf, cf}, {29'd0, exp});
    chk("R3", {29'd0, ovf, sgn, aux}, 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", {23'd0, zf, pf, cf, ovf, sgn, aux, st_inv, st_den, trap}, 32'd0);
  endtask

  task automatic t_order();
    do_reset();
    ord("R2 gt", P2, P1, 3'b000);
    ord("R2 lt", P1, P2, 3'b001);
    ord("R2 eq", P1, P1, 3'b100);
    ord("R6 neg lt", N2, N1, 3'b001);
    ord("R6 neg gt", N1, N2, 3'b000);
    ord("R6 mixed sign", N1, P1, 3'b001);
    ord("R5 zero", PZ, NZ, 3'b100);
    ord("R5 zero rev", NZ, PZ, 3'b100);
    ord("R6 inf gt max", PINF, PMAX, 3'b000);
    ord("R6 neg inf eq", NINF, NINF, 3'b100);
    ord("R6 neg inf lt", NINF, N2, 3'b001);
  endtask

  task automatic t_nan_quiet();
    do_reset();
    cmp(QNAN, P1, 1'b0, 1'b1, 1'b1);
    chk("R4 qnan flags", {29'd0, zf, pf, cf}, 32'd7);
    chk("R7 quiet qnan no invalid", {31'd0, st_inv}, 32'd0);
    cmp(P1, SNAN, 1'b0, 1'b1, 1'b1);
    chk("R7 quiet snan invalid", {31'd0, st_inv}, 32'd1);
    chk("R10 masked no trap", {31'd0, trap}, 32'd0);
  endtask

  task automatic t_nan_signal();
    do_reset();
    cmp(P1, QNAN, 1'b1, 1'b1, 1'b1);
    chk("R7 signal qnan invalid", {31'd0, st_inv}, 32'd1);
    chk("R10 masked flags written", {29'd0, zf, pf, cf}, 32'd7);
    chk("R10 masked trap low", {31'd0, trap}, 32'd0);
  endtask

  task automatic t_unmasked_inv();
    do_reset();
    ord("R2 setup", P1, P2, 3'b001);
    cmp(SNAN, P1, 1'b0, 1'b0, 1'b1);
    chk("R9 flags held", {29'd0, zf, pf, cf}, 32'd1);
    chk("R9 trap pulse", {31'd0, trap}, 32'd1);
    chk("R7 sticky", {31'd0, st_inv}, 32'd1);
    @(negedge clk);
    chk("R9 trap one cycle", {31'd0, trap}, 32'd0);
    chk("R11 sticky holds", {31'd0, st_inv}, 32'd1);
  endtask

  task automatic t_denormal();
    do_reset();
    cmp(DEN, PZ, 1'b0, 1'b1, 1'b1);
    chk("R8 den vs zero gt", {29'd0, zf, pf, cf}, 32'd0);
    chk("R8 sticky den", {31'd0, st_den}, 32'd1);
    chk("R10 den masked no trap", {31'd0, trap}, 32'd0);
    do_reset();
    ord("R2 setup eq", P2, P2, 3'b100);
    cmp(P1, DEN, 1'b0, 1'b1, 1'b0);
    chk("R9 den unmasked flags held", {29'd0, zf, pf, cf}, 32'd4);
    chk("R9 den trap", {31'd0, trap}, 32'd1);
    chk("R8 den sticky", {31'd0, st_den}, 32'd1);
    chk("R8 no invalid", {31'd0, st_inv}, 32'd0);
  endtask

  task automatic t_idle();
    do_reset();
    ord("R2 setup gt", P2, N1, 3'b000);
    a = N2; b = P2; valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 idle hold", {29'd0, zf, pf, cf}, 32'd0);
    chk("R11 idle no trap", {31'd0, trap}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_nan_quiet();
    t_nan_signal();
    t_unmasked_inv();
    t_denormal();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule